// File: doc/BRIEF.md
# Sampled Pulse Width Meter

This block measures the high time and the low time of an alternating high-speed data signal. It does not observe the signal directly. It receives a time-ordered stream of single-bit samples, each taken one resolution unit later than the one before. A Vernier sampling arrangement outside the block produces this stream. Every sample whose valid strobe is high advances the sample index by one.

A `start` pulse opens a sweep of `SPAN` samples. In that sweep the block finds the first three alternating edges. A jitter window places each edge at a median position. From the three positions the block forms the positive width, the negative width and their sum, which should equal the signal period. Both widths are checked against programmable limits in the same sweep, and a one-cycle `done` pulse reports the result. If the span ends before three edges are complete, the result is reported as a failure with a no-edge flag.

The controller is a four-state machine:
- `ST_IDLE` waits for `start` and moves to `ST_SEEK`.
- `ST_SEEK` looks for the next transition of the required polarity. A matching transition moves it to `ST_WIN`.
- `ST_WIN` collects the jitter window. When the window closes it returns to `ST_SEEK`, or it moves to `ST_EVAL` after the third edge.
- The last sample of the span moves `ST_SEEK` or `ST_WIN` to `ST_EVAL`.
- `ST_EVAL` registers the results and returns to `ST_IDLE`.
- A `start` in any state restarts the sweep in `ST_SEEK`.

Top module: `pulse_width_meter`

## Requirements
- R1: After reset, `done`, `no_edge`, `pos_width`, `neg_width`, `period_sum`, `pos_ok`, `neg_ok` and `pass` are all 0.
- R2: A `start` pulse begins a sweep. The first sample with `smp_valid` high in a later cycle has index 0. Cycles with `smp_valid` low are ignored. A `start` during a sweep discards it and begins a new one. Samples arriving outside a sweep have no effect on the held results.
- R3: A transition exists at index n (n ≥ 1) when sample n differs from sample n−1. A rising transition has sample n = 1. The first edge may have either polarity. The second and third edges must each have the opposite polarity to the edge before.
- R4: An edge whose first transition is at index f has a window of indices f to f+JIT_WIN−1. Let l be the last transition of the same polarity inside that window. The edge position is floor((f+l)/2). The span end truncates the window.
- R5: The positive width is the distance from a rising edge to the following falling edge. The negative width is the distance from a falling edge to the following rising edge. Both come from the first three edges of the same sweep.
- R6: Each width saturates at 2^WID_W−1.
- R7: `pos_ok` is 1 when pos_lo ≤ `pos_width` ≤ pos_hi. `neg_ok` is 1 when neg_lo ≤ `neg_width` ≤ neg_hi. `pass` is 1 when both are 1 and `no_edge` is 0.
- R8: `period_sum` is the third edge position minus the first edge position, saturated at 2^(WID_W+1)−1.
- R9: If the sample at index SPAN−1 is accepted before the third edge completes, the result has `no_edge` = 1 and both widths, `period_sum`, both ok flags and `pass` all 0.
- R10: `done` is a one-cycle pulse. It goes high after the second rising clock edge, counting from the edge that accepts the sample completing the sweep. The results stay stable until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) a sweep |
| smp_valid | input | 1 | Sample strobe |
| smp_bit | input | 1 | Sampled signal level |
| pos_lo | input | WID_W | Lower limit for the positive width |
| pos_hi | input | WID_W | Upper limit for the positive width |
| neg_lo | input | WID_W | Lower limit for the negative width |
| neg_hi | input | WID_W | Upper limit for the negative width |
| done | output | 1 | Result-ready pulse |
| no_edge | output | 1 | Fewer than three edges found in the span |
| pos_width | output | WID_W | Positive width in resolution units |
| neg_width | output | WID_W | Negative width in resolution units |
| period_sum | output | WID_W+1 | Sum of both widths (period) |
| pos_ok | output | 1 | Positive width within limits |
| neg_ok | output | 1 | Negative width within limits |
| pass | output | 1 | Overall result |

## Verification
The bench computes, for each sweep, the index of the closing sample, and records the clock edge that accepts that sample. It then expects `done` exactly one clock edge later, and checks `done` on every falling edge against that prediction. The result fields are compared on the falling edge where `done` is high. They are compared again after further samples and idle cycles, to confirm they are held.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_WIN,
        ST_EVAL
    } pwc_state_e;
endpackage

// File: rtl/pwc_sample_track.sv
module pwc_sample_track #(
    parameter int SPAN  = 256,
    parameter int IDX_W = $clog2(SPAN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             accept,
    input  logic             smp_bit,
    output logic [IDX_W-1:0] idx,
    output logic             trans,
    output logic             at_end
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SPAN - 1);

    logic [IDX_W-1:0] cnt_q;
    logic             prev_q;
    logic             have_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (restart) begin
            cnt_q       <= '0;
            have_prev_q <= 1'b0;
        end else if (accept) begin
            prev_q      <= smp_bit;
            have_prev_q <= 1'b1;
            if (cnt_q != LAST_IDX) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx    = cnt_q;
    assign at_end = (cnt_q == LAST_IDX);
    assign trans  = accept && have_prev_q && (smp_bit != prev_q);
endmodule

// File: rtl/pwc_limit_cmp.sv
module pwc_limit_cmp #(
    parameter int WID_W = 8
) (
    input  logic [WID_W-1:0] value,
    input  logic [WID_W-1:0] lo,
    input  logic [WID_W-1:0] hi,
    output logic             ok
);
    assign ok = (value >= lo) && (value <= hi);
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
    import pwc_pkg::*;
#(
    parameter int SPAN    = 256,
    parameter int WID_W   = 8,
    parameter int JIT_WIN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             smp_valid,
    input  logic             smp_bit,
    input  logic [WID_W-1:0] pos_lo,
    input  logic [WID_W-1:0] pos_hi,
    input  logic [WID_W-1:0] neg_lo,
    input  logic [WID_W-1:0] neg_hi,
    output logic             done,
    output logic             no_edge,
    output logic [WID_W-1:0] pos_width,
    output logic [WID_W-1:0] neg_width,
    output logic [WID_W:0]   period_sum,
    output logic             pos_ok,
    output logic             neg_ok,
    output logic             pass
);
    localparam int IDX_W = $clog2(SPAN);
    localparam int WMAX  = (1 << WID_W) - 1;
    localparam int SMAX  = (1 << (WID_W + 1)) - 1;

    pwc_state_e state_q, state_d;

    logic [IDX_W-1:0] idx, win_first, win_last, e0, e1, e2;
    logic [IDX_W-1:0] f_eff, l_eff, median;
    logic [IDX_W:0]   win_end, pair_sum;
    logic [1:0]       edge_cnt;
    logic             trans, at_end, accept;
    logic             win_pol, first_pol, miss;
    logic             cap_now, same_tr, close_now, last_edge;

    assign accept = smp_valid && !start &&
                    ((state_q == ST_SEEK) || (state_q == ST_WIN));

    pwc_sample_track #(.SPAN(SPAN), .IDX_W(IDX_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .accept  (accept),
        .smp_bit (smp_bit),
        .idx     (idx),
        .trans   (trans),
        .at_end  (at_end)
    );

    // edge capture, jitter window and median placement
    always_comb begin
        cap_now   = (state_q == ST_SEEK) && trans &&
                    ((edge_cnt == 2'd0) || (smp_bit != win_pol));
        same_tr   = (state_q == ST_WIN) && trans && (smp_bit == win_pol);
        win_end   = {1'b0, win_first} + (IDX_W+1)'(JIT_WIN - 1);
        close_now = (cap_now && at_end) ||
                    ((state_q == ST_WIN) && accept &&
                     (({1'b0, idx} == win_end) || at_end));
        f_eff     = cap_now ? idx : win_first;
        l_eff     = (cap_now || same_tr) ? idx : win_last;
        pair_sum  = {1'b0, f_eff} + {1'b0, l_eff};
        median    = pair_sum[IDX_W:1];
        last_edge = close_now && (edge_cnt == 2'd2);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEEK;
            ST_SEEK: begin
                if (start)                    state_d = ST_SEEK;
                else if (accept && at_end)    state_d = ST_EVAL;
                else if (cap_now)             state_d = ST_WIN;
            end
            ST_WIN: begin
                if (start)                    state_d = ST_SEEK;
                else if (last_edge)           state_d = ST_EVAL;
                else if (accept && at_end)    state_d = ST_EVAL;
                else if (close_now)           state_d = ST_SEEK;
            end
            ST_EVAL: state_d = start ? ST_SEEK : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // width evaluation
    function automatic logic [WID_W-1:0] sat_w(input logic [IDX_W-1:0] v);
        return (int'(v) > WMAX) ? WID_W'(WMAX) : WID_W'(v);
    endfunction

    function automatic logic [WID_W:0] sat_s(input logic [IDX_W-1:0] v);
        return (int'(v) > SMAX) ? (WID_W+1)'(SMAX) : (WID_W+1)'(v);
    endfunction

    logic [WID_W-1:0] cand [2];
    logic [WID_W-1:0] lo_v [2];
    logic [WID_W-1:0] hi_v [2];
    logic             ok_v [2];

    always_comb begin
        cand[0] = first_pol ? sat_w(e1 - e0) : sat_w(e2 - e1);
        cand[1] = first_pol ? sat_w(e2 - e1) : sat_w(e1 - e0);
        lo_v[0] = pos_lo;
        hi_v[0] = pos_hi;
        lo_v[1] = neg_lo;
        hi_v[1] = neg_hi;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lim
        pwc_limit_cmp #(.WID_W(WID_W)) u_cmp (
            .value (cand[g]),
            .lo    (lo_v[g]),
            .hi    (hi_v[g]),
            .ok    (ok_v[g])
        );
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt   <= '0;
            win_first  <= '0;
            win_last   <= '0;
            win_pol    <= 1'b0;
            first_pol  <= 1'b0;
            miss       <= 1'b0;
            e0         <= '0;
            e1         <= '0;
            e2         <= '0;
            done       <= 1'b0;
            no_edge    <= 1'b0;
            pos_width  <= '0;
            neg_width  <= '0;
            period_sum <= '0;
            pos_ok     <= 1'b0;
            neg_ok     <= 1'b0;
            pass       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                edge_cnt <= '0;
                miss     <= 1'b0;
            end else begin
                if (cap_now) begin
                    win_first <= idx;
                    win_last  <= idx;
                    win_pol   <= smp_bit;
                    if (edge_cnt == 2'd0) first_pol <= smp_bit;
                end
                if (same_tr) win_last <= idx;
                if (close_now) begin
                    if (edge_cnt == 2'd0)      e0 <= median;
                    else if (edge_cnt == 2'd1) e1 <= median;
                    else                       e2 <= median;
                    edge_cnt <= edge_cnt + 2'd1;
                end
                if (accept && at_end && !last_edge) miss <= 1'b1;
                if (state_q == ST_EVAL) begin
                    done <= 1'b1;
                    if (miss) begin
                        no_edge    <= 1'b1;
                        pos_width  <= '0;
                        neg_width  <= '0;
                        period_sum <= '0;
                        pos_ok     <= 1'b0;
                        neg_ok     <= 1'b0;
                        pass       <= 1'b0;
                    end else begin
                        no_edge    <= 1'b0;
                        pos_width  <= cand[0];
                        neg_width  <= cand[1];
                        period_sum <= sat_s(e2 - e0);
                        pos_ok     <= ok_v[0];
                        neg_ok     <= ok_v[1];
                        pass       <= ok_v[0] && ok_v[1];
                    end
                end
            end
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    // R9
    no_edge_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_edge) |-> (!pass && !pos_ok && !neg_ok && pos_width == '0));

    // R8
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_edge && int'(pos_width) != WMAX && int'(neg_width) != WMAX)
        |-> (int'(period_sum) == int'(pos_width) + int'(neg_width)));

    // R7
    pass_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (pos_ok && neg_ok && !no_edge));
endmodule

// File: tb/tb_pulse_width_meter.sv
`timescale 1ns/1ps
module tb_pulse_width_meter;
    localparam int SPAN = 64;
    localparam int WW   = 5;
    localparam int JW   = 6;
    localparam int WMAX = (1 << WW) - 1;
    localparam int SMAX = (1 << (WW + 1)) - 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, smp_valid = 1'b0, smp_bit = 1'b0;
    logic [WW-1:0] pos_lo = '0, pos_hi = '0, neg_lo = '0, neg_hi = '0;
    logic done, no_edge, pos_ok, neg_ok, pass;
    logic [WW-1:0] pos_width, neg_width;
    logic [WW:0]   period_sum;

    pulse_width_meter #(.SPAN(SPAN), .WID_W(WW), .JIT_WIN(JW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .smp_bit(smp_bit),
        .pos_lo(pos_lo), .pos_hi(pos_hi), .neg_lo(neg_lo), .neg_hi(neg_hi),
        .done(done), .no_edge(no_edge), .pos_width(pos_width), .neg_width(neg_width),
        .period_sum(period_sum), .pos_ok(pos_ok), .neg_ok(neg_ok), .pass(pass));

    always #2 clk = ~clk;

    int checks = 0, failures = 0, edge_no = 0;
    logic pat [SPAN];
    int exp_close, exp_pos, exp_neg, exp_sum;
    bit exp_noedge, exp_pok, exp_nok, exp_pass;

    always @(posedge clk) begin
        edge_no <= edge_no + 1;
        if (edge_no > 100000) begin
            failures = failures + 1;
            $display("FAIL R10 watchdog expired: actual=%0d cycles expected<=100000", edge_no);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic mk_square(input bit lvl, input int off, input int hi, input int lo);
        for (int n = 0; n < SPAN; n++) begin
            if (n < off) pat[n] = lvl;
            else begin
                int seg1 = lvl ? lo : hi;
                int ph = (n - off) % (hi + lo);
                pat[n] = (ph < seg1) ? ~lvl : lvl;
            end
        end
    endtask

    // behavioural reference for one sweep (R3, R4, R5, R6, R7, R8, R9)
    task automatic model();
        int e[3]; int ec = 0, f = 0, l = 0; bit wp = 0, fp = 0, inwin = 0;
        exp_close = -1; exp_noedge = 0;
        for (int n = 0; n < SPAN && exp_close < 0; n++) begin
            bit tr = (n > 0) && (pat[n] != pat[n-1]);
            bit closing = 0;
            if (!inwin) begin
                if (tr && (ec == 0 || pat[n] != wp)) begin
                    f = n; l = n; wp = pat[n];
                    if (ec == 0) fp = pat[n];
                    inwin = 1;
                    if (n == SPAN - 1) closing = 1;
                end
            end else begin
                if (tr && pat[n] == wp) l = n;
                if (n == f + JW - 1 || n == SPAN - 1) closing = 1;
            end
            if (closing) begin
                e[ec] = (f + l) / 2; ec++; inwin = 0;
                if (ec == 3) exp_close = n;
            end
            if (exp_close < 0 && n == SPAN - 1) begin
                exp_close = n; exp_noedge = 1;
            end
        end
        if (exp_noedge) begin
            exp_pos = 0; exp_neg = 0; exp_sum = 0; exp_pok = 0; exp_nok = 0; exp_pass = 0;
        end else begin
            int d1 = e[1] - e[0], d2 = e[2] - e[1];
            exp_pos = fp ? d1 : d2;
            exp_neg = fp ? d2 : d1;
            if (exp_pos > WMAX) exp_pos = WMAX;
            if (exp_neg > WMAX) exp_neg = WMAX;
            exp_sum = e[2] - e[0];
            if (exp_sum > SMAX) exp_sum = SMAX;
            exp_pok = (exp_pos >= pos_lo) && (exp_pos <= pos_hi);
            exp_nok = (exp_neg >= neg_lo) && (exp_neg <= neg_hi);
            exp_pass = exp_pok && exp_nok;
        end
    endtask

    task automatic check_results(input string tag);
        check("R5", {tag, " pos_width"}, pos_width, exp_pos);
        check("R5", {tag, " neg_width"}, neg_width, exp_neg);
        check("R8", {tag, " period_sum"}, period_sum, exp_sum);
        check("R7", {tag, " pos_ok"}, pos_ok, exp_pok);
        check("R7", {tag, " neg_ok"}, neg_ok, exp_nok);
        check("R7", {tag, " pass"}, pass, exp_pass);
        check("R9", {tag, " no_edge"}, no_edge, exp_noedge);
    endtask

    task automatic cyc_check(input int acc_edge, input string tag);
        bit exp_done = (acc_edge >= 0) && (edge_no == acc_edge + 1);
        check("R10", {tag, " done timing"}, done, exp_done);
        if (exp_done) check_results(tag);
    endtask

    task automatic run_sweep(input string tag, input bit gaps);
        int acc_edge = -1;
        int i = 0;
        model();
        @(negedge clk); start = 1; smp_valid = 0;
        @(negedge clk); start = 0;
        check("R2", {tag, " done after start"}, done, 0);
        while (i < SPAN && acc_edge < 0) begin
            if (gaps && (i % 3 == 1)) begin
                smp_valid = 0; smp_bit = ~pat[i];
                @(negedge clk); cyc_check(acc_edge, tag);
            end
            smp_valid = 1; smp_bit = pat[i];
            if (i == exp_close) acc_edge = edge_no + 1;
            @(negedge clk);
            if (acc_edge < 0) cyc_check(acc_edge, tag);
            i++;
        end
        for (int k = 0; k < 4; k++) begin
            smp_valid = 1; smp_bit = k[0];
            if (k == 0) cyc_check(acc_edge, tag);
            @(negedge clk); cyc_check(acc_edge, tag);
        end
        smp_valid = 0;
        check_results({tag, " held"}); // R10 results hold, R2 late samples ignored
    endtask

    task automatic set_lim(input int plo, input int phi, input int nlo, input int nhi);
        pos_lo = WW'(plo); pos_hi = WW'(phi); neg_lo = WW'(nlo); neg_hi = WW'(nhi);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "done", done, 0);
        check("R1", "no_edge", no_edge, 0);
        check("R1", "pos_width", pos_width, 0);
        check("R1", "period_sum", period_sum, 0);
        check("R1", "pass", pass, 0);
        rst_n = 1;
        @(negedge clk);

        // R5 R7 clean square, limits exactly at boundaries
        mk_square(0, 3, 10, 10); set_lim(10, 12, 8, 10);
        run_sweep("square", 0);
        check("R7", "square pass literal", pass, 1);
        check("R5", "square pos literal", pos_width, 10);

        // R3 first edge falling, pos above limit
        mk_square(1, 5, 12, 8); set_lim(8, 11, 8, 10);
        run_sweep("falling_first", 0);
        check("R7", "falling_first pos_ok literal", pos_ok, 0);
        check("R3", "falling_first neg literal", neg_width, 8);

        // R4 jitter around two edges
        mk_square(0, 3, 10, 10); pat[14] = 1; pat[24] = 0; pat[26] = 0;
        set_lim(0, 31, 0, 31);
        run_sweep("jitter", 0);
        check("R4", "jitter pos literal", pos_width, 11);

        // R6 saturation
        mk_square(0, 2, 35, 20); set_lim(0, 31, 0, 31);
        run_sweep("saturate", 0);
        check("R6", "saturate pos literal", pos_width, WMAX);
        check("R8", "saturate sum literal", period_sum, 55);

        // R9 no transitions, and only two edges
        for (int n = 0; n < SPAN; n++) pat[n] = 0;
        run_sweep("flat", 0);
        check("R9", "flat no_edge literal", no_edge, 1);
        mk_square(0, 10, 40, 40);
        run_sweep("two_edges", 0);

        // R2 invalid cycles ignored
        mk_square(0, 3, 10, 10); set_lim(10, 12, 8, 10);
        run_sweep("gaps", 1);

        // R2 restart discards partial sweep
        @(negedge clk); start = 1; smp_valid = 0;
        @(negedge clk); start = 0;
        for (int n = 0; n < 20; n++) begin
            smp_valid = 1; smp_bit = (n > 4);
            @(negedge clk);
            check("R2", "aborted sweep done", done, 0);
        end
        smp_valid = 0;
        mk_square(1, 5, 12, 8); set_lim(8, 12, 8, 8);
        run_sweep("restart", 0);

        // R4 R9 window truncated at span end, and third edge on last sample
        mk_square(0, 1, 30, 30); pat[62] = 0; set_lim(0, 31, 0, 31);
        run_sweep("trunc", 0);
        mk_square(0, 3, 30, 30);
        run_sweep("last_sample", 0);
        check("R9", "last_sample no_edge literal", no_edge, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule